// File: doc/BRIEF.md
# Programmable TFT Raster Timing Generator

This block produces the raster timing for a generic active-matrix (TFT) panel. It runs from the pixel clock and keeps a pixel counter and a line counter. From these counters and a set of static configuration fields it derives four signals: a line sync pulse, a frame sync pulse, a display-enable (data-ready) strobe, and a shift clock enable for the panel. It also passes 18-bit pixel data through to the panel. Outside the visible area, that data is blanked.

Each configuration field is given in a raw, encoded form rather than as a plain count. Some fields count in units of eight pixels. Some carry a bias of one or five. Some are used as they are. The block decodes every field to its true position or length. The encoded fields are sampled only at the first pixel of a frame, so a frame never mixes old and new timings. The bench and any other user can safely rewrite the fields at any time.

All panel outputs are registered. In any cycle, the sync, enable and data outputs describe the raster position shown on the counter outputs in that same cycle.

Top module: `tft_raster_gen`

## Requirements
- R1: While reset is asserted, and for two clock edges after it is released, every output is 0. This covers both syncs, the enable, the shift enable, the pixel data and both counters.
- R2: The pixel counter runs from 0 to HT-1 and then wraps to 0. HT = (line-total field + 1) * 8 pixels.
- R3: The line counter advances by one each time the pixel counter wraps. It runs from 0 to VT-1, where VT = line-count field + 1, and it holds its value otherwise.
- R4: The line sync window starts at pixel (start field + 1) and lasts (width field + 1) pixels. A pixel position p lies in a window [S, S+L) when either p or p+total falls inside that range, so a window that runs past the end of a line continues at its start.
- R5: The frame sync window starts at line (start field), with no bias. It lasts (width field + 1) lines and follows the same wrap rule over VT. It is judged on the line counter alone.
- R6: A sync polarity bit of 1 makes that sync active high. A polarity bit of 0 makes it active low, so the output is 1 outside its window.
- R7: The display enable is high only when two conditions hold under the wrap rule. The pixel counter must lie in [hstart + 5, hstart + 5 + (hlen field + 1) * 8). The line counter must lie in [vstart, vstart + vlen field + 1). The display width is therefore at least 8 pixels and always a multiple of 8.
- R8: The pixel data output equals the pixel input sampled at the same edge when the display enable is high. At all other times it is all zeros.
- R9: The shift clock enable is high on every pixel clock after reset.
- R10: All configuration fields, including polarities, are sampled at pixel 0 of line 0 and used for that whole frame. Changes made during a frame have no effect until the next frame begins.
- R11: The outputs carry one cycle of latency. In each cycle, the syncs, enable and data correspond to the pixel and line counts shown on the counter outputs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| htot_f | input | 7 | Line total field, HT = (f+1)*8 |
| hact_f | input | 7 | Display width field, (f+1)*8 pixels |
| hact_start_f | input | 10 | Display start field, f+5 pixels |
| hsync_start_f | input | 10 | Line sync start field, f+1 pixels |
| hsync_wid_f | input | 7 | Line sync width field, f+1 pixels |
| vtot_f | input | 10 | Frame total field, VT = f+1 lines |
| vact_f | input | 10 | Display height field, f+1 lines |
| vact_start_f | input | 10 | Display first line, f |
| vsync_start_f | input | 10 | Frame sync first line, f |
| vsync_wid_f | input | 3 | Frame sync width field, f+1 lines |
| hsync_pol | input | 1 | Line sync polarity, 1 active high |
| vsync_pol | input | 1 | Frame sync polarity, 1 active high |
| pix_in | input | 18 | Pixel data from upstream |
| line_sync | output | 1 | Line sync pulse |
| frame_sync | output | 1 | Frame sync pulse |
| data_rdy | output | 1 | Display enable strobe |
| shift_en | output | 1 | Panel shift clock enable |
| pix_out | output | 18 | Pixel data to panel, zero when blanked |
| h_cnt | output | 10 | Pixel position of the current outputs |
| v_cnt | output | 10 | Line position of the current outputs |

## Verification
Two events can fall in the same cycle. One is the reload of the configuration shadow. The other is the return of both counters to pixel 0 of line 0. The bench waits until the next pixel is the last pixel of a frame, then changes the line total and other fields in that cycle. It then judges two things: the last pixel must still follow the old timing, and the very first line of the new frame must run to the new length rather than the old one. A mid-frame rewrite is provoked separately, and the frame in progress must keep its old line length.

// File: rtl/tft_timing_pkg.sv
`timescale 1ns/1ps
package tft_timing_pkg;

  // Raw field widths as presented at the block edge
  localparam int HF_W  = 7;   // fields counted in units of 8 pixels
  localparam int HP_W  = 10;  // horizontal position fields
  localparam int VF_W  = 10;  // vertical fields
  localparam int VPW_W = 3;   // frame sync width field
  // Working width for decoded positions: holds start + length + wrap
  localparam int POS_W = 12;

  // Window slots
  localparam int WIN_LS  = 0;
  localparam int WIN_HDE = 1;
  localparam int WIN_FS  = 2;
  localparam int WIN_VDE = 3;
  localparam int NUM_WIN = 4;

  typedef struct packed {
    logic [HF_W-1:0]  htot;
    logic [HF_W-1:0]  hact;
    logic [HP_W-1:0]  hact_start;
    logic [HP_W-1:0]  hsync_start;
    logic [HF_W-1:0]  hsync_wid;
    logic [VF_W-1:0]  vtot;
    logic [VF_W-1:0]  vact;
    logic [VF_W-1:0]  vact_start;
    logic [VF_W-1:0]  vsync_start;
    logic [VPW_W-1:0] vsync_wid;
    logic             hpol;
    logic             vpol;
  } tft_raw_cfg_t;

  typedef struct packed {
    logic [POS_W-1:0] tot;
    logic [POS_W-1:0] start;
    logic [POS_W-1:0] len;
  } tft_win_cfg_t;

endpackage

// File: rtl/tft_cfg_shadow.sv
`timescale 1ns/1ps
module tft_cfg_shadow
  import tft_timing_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  tft_raw_cfg_t raw_i,
  output tft_raw_cfg_t eff_o
);

  tft_raw_cfg_t shadow_q;

  // At the first pixel the live fields take effect at once
  always_comb begin
    eff_o = frame_start ? raw_i : shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (frame_start) begin
      shadow_q <= raw_i;
    end
  end

endmodule

// File: rtl/tft_raster_cnt.sv
`timescale 1ns/1ps
module tft_raster_cnt
  import tft_timing_pkg::*;
#(
  parameter int HC_W = 10,
  parameter int VC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] htot,
  input  logic [POS_W-1:0] vtot,
  output logic [HC_W-1:0]  h_q,
  output logic [VC_W-1:0]  v_q,
  output logic             frame_start
);

  logic            h_last;
  logic            v_last;
  logic [HC_W-1:0] h_nx;
  logic [VC_W-1:0] v_nx;

  always_comb begin
    h_last      = (POS_W'(h_q) == (htot - POS_W'(1)));
    v_last      = (POS_W'(v_q) == (vtot - POS_W'(1)));
    frame_start = (h_q == '0) && (v_q == '0);
    h_nx        = h_last ? '0 : h_q + HC_W'(1);
    v_nx        = v_q;
    if (h_last) begin
      v_nx = v_last ? '0 : v_q + VC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_nx;
      v_q <= v_nx;
    end
  end

endmodule

// File: rtl/tft_win.sv
`timescale 1ns/1ps
module tft_win
  import tft_timing_pkg::*;
(
  input  logic [POS_W-1:0] pos_i,
  input  tft_win_cfg_t     cfg_i,
  output logic             hit_o
);

  logic [POS_W-1:0] pos_wrap;
  logic [POS_W-1:0] stop;

  // A position is inside if it, or its copy one total later, is in range
  always_comb begin
    pos_wrap = pos_i + cfg_i.tot;
    stop     = cfg_i.start + cfg_i.len;
    hit_o    = ((pos_i    >= cfg_i.start) && (pos_i    < stop)) ||
               ((pos_wrap >= cfg_i.start) && (pos_wrap < stop));
  end

endmodule

// File: rtl/tft_raster_gen.sv
`timescale 1ns/1ps
module tft_raster_gen
  import tft_timing_pkg::*;
#(
  parameter int PIX_W = 18,
  parameter int HC_W  = HF_W + 3,
  parameter int VC_W  = VF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HF_W-1:0]   htot_f,
  input  logic [HF_W-1:0]   hact_f,
  input  logic [HP_W-1:0]   hact_start_f,
  input  logic [HP_W-1:0]   hsync_start_f,
  input  logic [HF_W-1:0]   hsync_wid_f,
  input  logic [VF_W-1:0]   vtot_f,
  input  logic [VF_W-1:0]   vact_f,
  input  logic [VF_W-1:0]   vact_start_f,
  input  logic [VF_W-1:0]   vsync_start_f,
  input  logic [VPW_W-1:0]  vsync_wid_f,
  input  logic              hsync_pol,
  input  logic              vsync_pol,
  input  logic [PIX_W-1:0]  pix_in,
  output logic              line_sync,
  output logic              frame_sync,
  output logic              data_rdy,
  output logic              shift_en,
  output logic [PIX_W-1:0]  pix_out,
  output logic [HC_W-1:0]   h_cnt,
  output logic [VC_W-1:0]   v_cnt
);

  localparam int RST_STAGES = 2;

  // Reset: asserted at once, released after RST_STAGES edges
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  tft_raw_cfg_t cfg_raw;
  tft_raw_cfg_t cfg_eff;
  logic         frame_start;
  logic [HC_W-1:0] h_q;
  logic [VC_W-1:0] v_q;

  always_comb begin
    cfg_raw.htot        = htot_f;
    cfg_raw.hact        = hact_f;
    cfg_raw.hact_start  = hact_start_f;
    cfg_raw.hsync_start = hsync_start_f;
    cfg_raw.hsync_wid   = hsync_wid_f;
    cfg_raw.vtot        = vtot_f;
    cfg_raw.vact        = vact_f;
    cfg_raw.vact_start  = vact_start_f;
    cfg_raw.vsync_start = vsync_start_f;
    cfg_raw.vsync_wid   = vsync_wid_f;
    cfg_raw.hpol        = hsync_pol;
    cfg_raw.vpol        = vsync_pol;
  end

  tft_cfg_shadow u_shadow (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .frame_start (frame_start),
    .raw_i       (cfg_raw),
    .eff_o       (cfg_eff)
  );

  // Field decode to true positions and lengths
  logic [POS_W-1:0] ht;
  logic [POS_W-1:0] vt;
  tft_win_cfg_t     win_cfg [NUM_WIN];
  logic [POS_W-1:0] win_pos [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;

  always_comb begin
    ht = POS_W'({cfg_eff.htot, 3'b000}) + POS_W'(8);
    vt = POS_W'(cfg_eff.vtot) + POS_W'(1);

    win_cfg[WIN_LS].tot    = ht;
    win_cfg[WIN_LS].start  = POS_W'(cfg_eff.hsync_start) + POS_W'(1);
    win_cfg[WIN_LS].len    = POS_W'(cfg_eff.hsync_wid) + POS_W'(1);
    win_pos[WIN_LS]        = POS_W'(h_q);

    win_cfg[WIN_HDE].tot   = ht;
    win_cfg[WIN_HDE].start = POS_W'(cfg_eff.hact_start) + POS_W'(5);
    win_cfg[WIN_HDE].len   = POS_W'({cfg_eff.hact, 3'b000}) + POS_W'(8);
    win_pos[WIN_HDE]       = POS_W'(h_q);

    win_cfg[WIN_FS].tot    = vt;
    win_cfg[WIN_FS].start  = POS_W'(cfg_eff.vsync_start);
    win_cfg[WIN_FS].len    = POS_W'(cfg_eff.vsync_wid) + POS_W'(1);
    win_pos[WIN_FS]        = POS_W'(v_q);

    win_cfg[WIN_VDE].tot   = vt;
    win_cfg[WIN_VDE].start = POS_W'(cfg_eff.vact_start);
    win_cfg[WIN_VDE].len   = POS_W'(cfg_eff.vact) + POS_W'(1);
    win_pos[WIN_VDE]       = POS_W'(v_q);
  end

  tft_raster_cnt #(
    .HC_W (HC_W),
    .VC_W (VC_W)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .htot        (ht),
    .vtot        (vt),
    .h_q         (h_q),
    .v_q         (v_q),
    .frame_start (frame_start)
  );

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    tft_win u_win (
      .pos_i (win_pos[gi]),
      .cfg_i (win_cfg[gi]),
      .hit_o (win_hit[gi])
    );
  end

  // Output stage
  logic             ls_nx;
  logic             fs_nx;
  logic             de_nx;
  logic [PIX_W-1:0] pix_nx;

  always_comb begin
    ls_nx  = cfg_eff.hpol ? win_hit[WIN_LS] : ~win_hit[WIN_LS];
    fs_nx  = cfg_eff.vpol ? win_hit[WIN_FS] : ~win_hit[WIN_FS];
    de_nx  = win_hit[WIN_HDE] & win_hit[WIN_VDE];
    pix_nx = de_nx ? pix_in : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      line_sync  <= 1'b0;
      frame_sync <= 1'b0;
      data_rdy   <= 1'b0;
      shift_en   <= 1'b0;
      pix_out    <= '0;
      h_cnt      <= '0;
      v_cnt      <= '0;
    end else begin
      line_sync  <= ls_nx;
      frame_sync <= fs_nx;
      data_rdy   <= de_nx;
      shift_en   <= 1'b1;
      pix_out    <= pix_nx;
      h_cnt      <= h_q;
      v_cnt      <= v_q;
    end
  end

endmodule

// File: rtl/tft_raster_gen_chk.sv
`timescale 1ns/1ps
module tft_raster_gen_chk
  import tft_timing_pkg::*;
#(
  parameter int PIX_W = 18,
  parameter int HC_W  = 10,
  parameter int VC_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input tft_raw_cfg_t     cfg_eff,
  input logic [HC_W-1:0]  h_cnt,
  input logic [VC_W-1:0]  v_cnt,
  input logic             data_rdy,
  input logic             shift_en,
  input logic [PIX_W-1:0] pix_out
);

  // R2: a nonzero pixel count follows its predecessor by one
  p_hstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != '0) |-> (h_cnt == $past(h_cnt) + HC_W'(1)));

  // R3: the line count only moves when the pixel count returns to 0
  p_vhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != '0) |-> $stable(v_cnt));

  // R8: blanked cycles carry zero data
  p_pix_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rdy |-> (pix_out == '0));

  // R9: shift enable stays high once running
  p_shift_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> shift_en);

  // R10: effective timing cannot change except at a frame start
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (frame_start || $stable(cfg_eff)));

endmodule

bind tft_raster_gen tft_raster_gen_chk #(
  .PIX_W (PIX_W),
  .HC_W  (HC_W),
  .VC_W  (VC_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .frame_start (frame_start),
  .cfg_eff     (cfg_eff),
  .h_cnt       (h_cnt),
  .v_cnt       (v_cnt),
  .data_rdy    (data_rdy),
  .shift_en    (shift_en),
  .pix_out     (pix_out)
);

// File: tb/tft_raster_gen_tb.sv
`timescale 1ns/1ps
module tft_raster_gen_tb_top;

  logic        clk;
  logic        rst_n;
  logic [6:0]  htot_f, hact_f, hsync_wid_f;
  logic [9:0]  hact_start_f, hsync_start_f;
  logic [9:0]  vtot_f, vact_f, vact_start_f, vsync_start_f;
  logic [2:0]  vsync_wid_f;
  logic        hsync_pol, vsync_pol;
  logic [17:0] pix_in;
  logic        line_sync, frame_sync, data_rdy, shift_en;
  logic [17:0] pix_out;
  logic [9:0]  h_cnt, v_cnt;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // model state
  int mh, mv;
  int m_ht, m_hdp, m_hdps, m_hps, m_hpw;
  int m_vt, m_vdp, m_vdps, m_vps, m_vpw;
  int m_hpol, m_vpol;
  int obs_h;

  tft_raster_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .htot_f(htot_f), .hact_f(hact_f), .hact_start_f(hact_start_f),
    .hsync_start_f(hsync_start_f), .hsync_wid_f(hsync_wid_f),
    .vtot_f(vtot_f), .vact_f(vact_f), .vact_start_f(vact_start_f),
    .vsync_start_f(vsync_start_f), .vsync_wid_f(vsync_wid_f),
    .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .pix_in(pix_in),
    .line_sync(line_sync), .frame_sync(frame_sync), .data_rdy(data_rdy),
    .shift_en(shift_en), .pix_out(pix_out), .h_cnt(h_cnt), .v_cnt(v_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Membership by walking the window: positions past the total fold once
  function automatic int in_win(int pos, int tot, int s, int l);
    for (int i = 0; i < l; i++) begin
      int p = s + i;
      if (p < tot && p == pos) return 1;
      if (p >= tot && p < 2 * tot && p - tot == pos) return 1;
    end
    return 0;
  endfunction

  task automatic latch_cfg();
    m_ht   = (int'(htot_f) + 1) * 8;
    m_hdp  = (int'(hact_f) + 1) * 8;
    m_hdps = int'(hact_start_f) + 5;
    m_hps  = int'(hsync_start_f) + 1;
    m_hpw  = int'(hsync_wid_f) + 1;
    m_vt   = int'(vtot_f) + 1;
    m_vdp  = int'(vact_f) + 1;
    m_vdps = int'(vact_start_f);
    m_vps  = int'(vsync_start_f);
    m_vpw  = int'(vsync_wid_f) + 1;
    m_hpol = int'(hsync_pol);
    m_vpol = int'(vsync_pol);
  endtask

  // One pixel: predict, clock, compare (R11 alignment), advance model
  task automatic step();
    int e_ls, e_fs, e_de, e_pix, hs, vs;
    if (mh == 0 && mv == 0) latch_cfg();
    hs    = in_win(mh, m_ht, m_hps, m_hpw);
    vs    = in_win(mv, m_vt, m_vps, m_vpw);
    e_ls  = m_hpol ? hs : 1 - hs;
    e_fs  = m_vpol ? vs : 1 - vs;
    e_de  = in_win(mh, m_ht, m_hdps, m_hdp) & in_win(mv, m_vt, m_vdps, m_vdp);
    e_pix = e_de ? int'(pix_in) : 0;
    @(posedge clk);
    @(negedge clk);
    chk("R2 pixel count (R11)", int'(h_cnt), mh);
    chk("R3 line count (R11)", int'(v_cnt), mv);
    chk("R4 R6 line sync", int'(line_sync), e_ls);
    chk("R5 R6 frame sync", int'(frame_sync), e_fs);
    chk("R7 display enable", int'(data_rdy), e_de);
    chk("R8 pixel data", int'(pix_out), e_pix);
    chk("R9 shift enable", int'(shift_en), 1);
    obs_h = int'(h_cnt);
    pix_in = 18'($urandom);
    mh++;
    if (mh == m_ht) begin
      mh = 0;
      mv++;
      if (mv == m_vt) mv = 0;
    end
  endtask

  task automatic run_steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_base();
    htot_f = 7'd3;  hact_f = 7'd1;  hact_start_f = 10'd4;
    hsync_start_f = 10'd1; hsync_wid_f = 7'd3;
    vtot_f = 10'd7; vact_f = 10'd4; vact_start_f = 10'd2;
    vsync_start_f = 10'd0; vsync_wid_f = 3'd1;
    hsync_pol = 1'b0; vsync_pol = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mh = 0;
    mv = 0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  // R1: all outputs idle in and just after reset
  task automatic t_reset();
    set_base();
    pix_in = 18'h3ffff;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 line sync in reset", int'(line_sync), 0);
    chk("R1 frame sync in reset", int'(frame_sync), 0);
    chk("R1 enable in reset", int'(data_rdy), 0);
    chk("R1 shift in reset", int'(shift_en), 0);
    chk("R1 data in reset", int'(pix_out), 0);
    rst_n = 1'b1;
    mh = 0;
    mv = 0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R1 shift after release", int'(shift_en), 0);
    chk("R1 counters after release", int'(h_cnt) + int'(v_cnt), 0);
    chk("R1 line sync after release", int'(line_sync), 0);
  endtask

  // R2..R9 over two frames of an ordinary raster, active-low syncs
  task automatic t_basic();
    set_base();
    do_reset();
    run_steps(2 * 32 * 8);
  endtask

  // R4 R5 R7: windows that wrap past the end of line and frame
  task automatic t_wrap();
    set_base();
    hsync_start_f = 10'd28; hsync_wid_f = 7'd7;
    hact_start_f  = 10'd20;
    vsync_start_f = 10'd6;  vsync_wid_f = 3'd3;
    vact_start_f  = 10'd5;
    hsync_pol = 1'b1; vsync_pol = 1'b1;
    do_reset();
    run_steps(2 * 32 * 8);
  endtask

  // R6: mixed polarities
  task automatic t_pol();
    set_base();
    hsync_pol = 1'b1; vsync_pol = 1'b0;
    do_reset();
    run_steps(32 * 8);
  endtask

  // R7 minimum sizes: 8-pixel line, one-line frame, sync wider than frame
  task automatic t_min();
    set_base();
    htot_f = 7'd0; hact_f = 7'd0; hact_start_f = 10'd0;
    vtot_f = 10'd0; vact_f = 10'd0; vact_start_f = 10'd0;
    vsync_wid_f = 3'd7;
    do_reset();
    run_steps(40);
    chk("R7 full-line enable at minimum width", int'(data_rdy), 1);
  endtask

  // R10: mid-frame rewrite ignored; rewrite on the last pixel of a frame
  task automatic t_cfg();
    int hmax;
    set_base();
    do_reset();
    run_steps(128);
    htot_f = 7'd1; vtot_f = 10'd3; hsync_pol = 1'b1; hact_start_f = 10'd0;
    hmax = 0;
    while (!(mh == 0 && mv == 0)) begin
      step();
      if (obs_h > hmax) hmax = obs_h;
    end
    chk("R10 old line length kept mid-frame", hmax, 31);
    run_steps(16 * 4);
    while (!(mh == m_ht - 1 && mv == m_vt - 1)) step();
    htot_f = 7'd2;
    step();
    chk("R10 last pixel of old frame", obs_h, 15);
    step();
    chk("R10 first pixel of new frame", obs_h, 0);
    run_steps(23);
    chk("R10 new line length applied", obs_h, 23);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pix_in = '0;
    set_base();
    t_reset();
    t_basic();
    t_wrap();
    t_pol();
    t_min();
    t_cfg();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule